// File: doc/BRIEF.md
# TDM Frame and Clock Timing Generator

This block sets up the timing reference for a time-division switching system. A 16.384 MHz master clock runs it. From that clock it keeps a per-frame tick index of 2048 master clocks. It rebuilds the 4.096 MHz and 2.048 MHz bit clocks and a regenerated 8 kHz frame pulse from that index. It also produces two memory framing signals:

- a short 8 kHz strobe for the connection store;
- a 4 kHz square wave, with its complement, for the data store.

The tick index is exported so that the serial/parallel converters can place their bits.

The index realigns to an external active-low frame pulse. That pulse is sampled on each falling edge of a phase-locked 4.096 MHz input clock. A delay select moves the realignment one master clock later. The memory framing signals keep fixed offsets from the boundary, and those offsets depend on the delay select. Between boundaries the index runs freely and wraps by itself.

Top module: `tdm_frame_timer`

## Requirements
- R1: While reset is high, and in the first cycle after it, the outputs hold these values: tick index 0, 4 MHz output low, 2 MHz output high, regenerated frame pulse low, connection strobe high, data-memory signal low and its complement high.
- R2: With no boundary detected, the tick index rises by one on every master clock and wraps from 2047 to 0.
- R3: A boundary is detected at a master clock edge where the 4 MHz input is seen low, was seen high at the previous edge, and the external frame pulse is low. With delay select low, the tick index becomes 0 on that same edge.
- R4: With delay select high, the tick index becomes 0 one master clock after the edge that detected the boundary.
- R5: The connection strobe is low for exactly 4 master clocks. It covers tick indices 1977..1980 with delay select low (71 clocks before the boundary) and 1979..1982 with delay select high (68 clocks before the boundary).
- R6: The data-memory signal inverts when the tick index goes from 63 to 64, and at no other time. This is 64 clocks after the boundary with delay select low and 65 with it high. Its period is therefore two frames.
- R7: The data-memory complement output is always the inverse of the data-memory signal.
- R8: The 4 MHz output is high for tick index mod 4 in {2,3} and low otherwise. The 2 MHz output is high for tick index mod 8 in {0..3} and low otherwise, so it rises as the index enters a multiple of 8.
- R9: The regenerated frame pulse is low for tick indices 2046, 2047, 0 and 1. This is one 4 MHz period centred on the falling edge of the 4 MHz output, and it contains a rising edge of the 2 MHz output.
- R10: A low external frame pulse without a falling edge on the 4 MHz input has no effect, and neither does a falling edge while the frame pulse is high. The tick index keeps counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16.384 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| c4_in | input | 1 | Phase-locked 4.096 MHz input clock |
| fp_n_in | input | 1 | External frame pulse, active low |
| dly_sel | input | 1 | Delay select: 1 moves the realignment one master clock later |
| tick_idx | output | 11 | Master clock index within the frame |
| c4_out | output | 1 | Regenerated 4.096 MHz clock |
| c2_out | output | 1 | Regenerated 2.048 MHz clock |
| fp_n_out | output | 1 | Regenerated 8 kHz frame pulse, active low |
| cm_fp_n | output | 1 | Connection-store strobe, active low |
| dm_fp | output | 1 | Data-store 4 kHz framing signal |
| dm_fp_n | output | 1 | Complement of dm_fp |

## Verification
The bench realigns the index at an arbitrary point mid-frame, under each delay setting. A design that loaded zero on the wrong edge would shift every output by one clock against the model. A design that used the same strobe offset for both delay settings would move the connection strobe by two clocks when the delay is high.

The bench holds the frame pulse low while the 4 MHz input stays high, which exposes a detector that acts on level rather than on edge. It also lets the index free-run past 2047, which catches a wrap at the wrong count. Two full frames after each realignment show whether the data-memory signal inverts once per frame, at index 64 and not elsewhere.

// File: rtl/tdm_timer_pkg.sv
package tdm_timer_pkg;

    localparam int unsigned TICKS_DEF      = 2048;
    localparam int unsigned C4_TICKS_DEF   = 4;
    localparam int unsigned CM_LEAD_NODLY  = 71;
    localparam int unsigned CM_LEAD_DLY    = 68;
    localparam int unsigned DM_LAG_NODLY   = 64;
    localparam int unsigned DM_LAG_DLY     = 65;

    typedef struct packed {
        logic c4;
        logic c2;
        logic fp_n;
        logic cm_n;
        logic dm;
        logic dm_n;
    } tdm_frame_bus_t;

    // First tick index of the connection strobe, counted on the tick index.
    // With the delay, index 0 sits one clock after the boundary.
    function automatic int unsigned cm_first(input int unsigned ticks,
                                             input int unsigned lead,
                                             input bit          delayed);
        return delayed ? (ticks - lead - 1) : (ticks - lead);
    endfunction

    // Tick index on which the data-memory signal has just inverted.
    function automatic int unsigned dm_first(input int unsigned lag,
                                             input bit          delayed);
        return delayed ? (lag - 1) : lag;
    endfunction

endpackage

// File: rtl/tdm_boundary_detect.sv
module tdm_boundary_detect (
    input  logic clk,
    input  logic rst,
    input  logic c4_in,
    input  logic fp_n_in,
    input  logic dly_sel,
    output logic load
);

    logic c4_q;
    logic hit;
    logic hit_q;

    // Falling edge of the 4 MHz input while the frame pulse is low.
    assign hit = c4_q & ~c4_in & ~fp_n_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            c4_q  <= 1'b0;
            hit_q <= 1'b0;
        end else begin
            c4_q  <= c4_in;
            hit_q <= hit;
        end
    end

    assign load = dly_sel ? hit_q : hit;

    p_delay_load_r4: assert property (@(posedge clk) disable iff (rst)
        (hit && dly_sel) ##1 dly_sel |-> load);

    p_nodelay_load_r3: assert property (@(posedge clk) disable iff (rst)
        (!dly_sel && !fp_n_in && !c4_in && c4_q) |-> load);

endmodule

// File: rtl/tdm_tick_counter.sv
module tdm_tick_counter #(
    parameter int unsigned TICKS = tdm_timer_pkg::TICKS_DEF,
    localparam int unsigned W    = $clog2(TICKS)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    output logic [W-1:0] idx
);

    localparam logic [W-1:0] LAST = W'(TICKS - 1);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            idx <= '0;
        end else if (idx == LAST) begin
            idx <= '0;
        end else begin
            idx <= idx + W'(1);
        end
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && idx != LAST) |=> idx == $past(idx) + W'(1));

    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && idx == LAST) |=> idx == '0);

    p_realign_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> idx == '0);

endmodule

// File: rtl/tdm_frame_decode.sv
module tdm_frame_decode
    import tdm_timer_pkg::*;
#(
    parameter int unsigned TICKS    = TICKS_DEF,
    parameter int unsigned C4_TICKS = C4_TICKS_DEF,
    parameter int unsigned CM_LEAD0 = CM_LEAD_NODLY,
    parameter int unsigned CM_LEAD1 = CM_LEAD_DLY,
    parameter int unsigned DM_LAG0  = DM_LAG_NODLY,
    parameter int unsigned DM_LAG1  = DM_LAG_DLY,
    localparam int unsigned W       = $clog2(TICKS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           dly_sel,
    input  logic [W-1:0]   idx,
    output tdm_frame_bus_t bus
);

    localparam int unsigned C4_BIT = $clog2(C4_TICKS) - 1;
    localparam int unsigned C2_BIT = $clog2(C4_TICKS);

    localparam logic [W-1:0] CM_LO0 = W'(cm_first(TICKS, CM_LEAD0, 1'b0));
    localparam logic [W-1:0] CM_LO1 = W'(cm_first(TICKS, CM_LEAD1, 1'b1));
    localparam logic [W-1:0] CM_HI0 = CM_LO0 + W'(C4_TICKS - 1);
    localparam logic [W-1:0] CM_HI1 = CM_LO1 + W'(C4_TICKS - 1);

    localparam logic [W-1:0] DM_PRE0 = W'(dm_first(DM_LAG0, 1'b0) - 1);
    localparam logic [W-1:0] DM_PRE1 = W'(dm_first(DM_LAG1, 1'b1) - 1);

    localparam logic [W-1:0] FP_LO = W'(TICKS - C4_TICKS / 2);
    localparam logic [W-1:0] FP_HI = W'(C4_TICKS / 2 - 1);

    logic [W-1:0] cm_lo;
    logic [W-1:0] cm_hi;
    logic [W-1:0] dm_pre;
    logic         dm_q;

    always_comb begin
        cm_lo  = dly_sel ? CM_LO1  : CM_LO0;
        cm_hi  = dly_sel ? CM_HI1  : CM_HI0;
        dm_pre = dly_sel ? DM_PRE1 : DM_PRE0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dm_q <= 1'b0;
        end else if (idx == dm_pre) begin
            dm_q <= ~dm_q;
        end
    end

    always_comb begin
        bus.c4   = idx[C4_BIT];
        bus.c2   = ~idx[C2_BIT];
        bus.fp_n = ~((idx >= FP_LO) || (idx <= FP_HI));
        bus.cm_n = ~((idx >= cm_lo) && (idx <= cm_hi));
        bus.dm   = dm_q;
        bus.dm_n = ~dm_q;
    end

    p_dm_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (idx != dm_pre) |=> $stable(bus.dm));

    p_dm_flip_r6: assert property (@(posedge clk) disable iff (rst)
        (idx == dm_pre) |=> bus.dm != $past(bus.dm));

    p_cm_start_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(bus.cm_n) |-> idx == cm_lo);

    p_c2_in_fp_r9: assert property (@(posedge clk) disable iff (rst)
        (idx == '0) |-> (bus.c2 && !bus.fp_n && !bus.c4));

endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_timer_pkg::*;
#(
    parameter int unsigned TICKS    = TICKS_DEF,
    parameter int unsigned C4_TICKS = C4_TICKS_DEF,
    parameter int unsigned CM_LEAD0 = CM_LEAD_NODLY,
    parameter int unsigned CM_LEAD1 = CM_LEAD_DLY,
    parameter int unsigned DM_LAG0  = DM_LAG_NODLY,
    parameter int unsigned DM_LAG1  = DM_LAG_DLY,
    localparam int unsigned W       = $clog2(TICKS)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         c4_in,
    input  logic         fp_n_in,
    input  logic         dly_sel,
    output logic [W-1:0] tick_idx,
    output logic         c4_out,
    output logic         c2_out,
    output logic         fp_n_out,
    output logic         cm_fp_n,
    output logic         dm_fp,
    output logic         dm_fp_n
);

    logic           load;
    tdm_frame_bus_t bus;

    tdm_boundary_detect u_detect (
        .clk     (clk),
        .rst     (rst),
        .c4_in   (c4_in),
        .fp_n_in (fp_n_in),
        .dly_sel (dly_sel),
        .load    (load)
    );

    tdm_tick_counter #(.TICKS(TICKS)) u_count (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .idx  (tick_idx)
    );

    tdm_frame_decode #(
        .TICKS    (TICKS),
        .C4_TICKS (C4_TICKS),
        .CM_LEAD0 (CM_LEAD0),
        .CM_LEAD1 (CM_LEAD1),
        .DM_LAG0  (DM_LAG0),
        .DM_LAG1  (DM_LAG1)
    ) u_decode (
        .clk     (clk),
        .rst     (rst),
        .dly_sel (dly_sel),
        .idx     (tick_idx),
        .bus     (bus)
    );

    assign c4_out   = bus.c4;
    assign c2_out   = bus.c2;
    assign fp_n_out = bus.fp_n;
    assign cm_fp_n  = bus.cm_n;
    assign dm_fp    = bus.dm;
    assign dm_fp_n  = bus.dm_n;

    p_dm_pair_r7: assert property (@(posedge clk) disable iff (rst)
        dm_fp != dm_fp_n);

endmodule

// File: tb/tdm_frame_timer_bench.sv
module tdm_frame_timer_bench;

    typedef struct {
        int idx;
        bit c4;
        bit c2;
        bit fp_n;
        bit cm_n;
        bit dm;
        bit dm_n;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        c4_in = 1'b0;
    logic        fp_n_in = 1'b1;
    logic        dly_sel = 1'b0;
    logic [10:0] tick_idx;
    logic        c4_out, c2_out, fp_n_out, cm_fp_n, dm_fp, dm_fp_n;

    int  checks = 0;
    int  errors = 0;
    int  ph = 0;
    int  edges = 0;
    bit  done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    tdm_frame_timer u_tdm_frame_timer (
        .clk      (clk),
        .rst      (rst),
        .c4_in    (c4_in),
        .fp_n_in  (fp_n_in),
        .dly_sel  (dly_sel),
        .tick_idx (tick_idx),
        .c4_out   (c4_out),
        .c2_out   (c2_out),
        .fp_n_out (fp_n_out),
        .cm_fp_n  (cm_fp_n),
        .dm_fp    (dm_fp),
        .dm_fp_n  (dm_fp_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model built from the requirements.
    int m_cnt = 0;
    bit m_dm = 0;
    bit m_c4 = 0;
    bit m_hit = 0;

    always @(posedge clk) begin
        exp_t e;
        int   cs;
        edges++;
        if (rst) begin
            m_cnt = 0; m_dm = 0; m_c4 = 0; m_hit = 0;
        end else begin
            bit hit_now;
            bit ld;
            hit_now = m_c4 && !c4_in && !fp_n_in;
            ld = dly_sel ? m_hit : hit_now;
            if (m_cnt == 63) m_dm = !m_dm;
            m_cnt = ld ? 0 : (m_cnt + 1) % 2048;
            m_c4 = c4_in;
            m_hit = hit_now;
        end
        cs = dly_sel ? 1979 : 1977;
        e.idx  = m_cnt;
        e.c4   = (m_cnt % 4) >= 2;
        e.c2   = (m_cnt % 8) < 4;
        e.fp_n = !(m_cnt >= 2046 || m_cnt <= 1);
        e.cm_n = !(m_cnt >= cs && m_cnt <= cs + 3);
        e.dm   = m_dm;
        e.dm_n = !m_dm;
        sb.push_back(e);
    end

    // Monitor: compares each expected item a little after the edge.
    always begin
        @(posedge clk);
        #3;
        if (sb.size() > 0 && !done) begin
            exp_t e;
            e = sb.pop_front();
            chk(int'(tick_idx) == e.idx, "R2 R3 R4 tick index", int'(tick_idx), e.idx);
            chk(cm_fp_n == e.cm_n, "R5 connection strobe", cm_fp_n, e.cm_n);
            chk(dm_fp == e.dm, "R6 data-memory signal", dm_fp, e.dm);
            chk(dm_fp_n == e.dm_n, "R7 data-memory complement", dm_fp_n, e.dm_n);
            chk(c4_out == e.c4, "R8 4 MHz output", c4_out, e.c4);
            chk(c2_out == e.c2, "R8 2 MHz output", c2_out, e.c2);
            chk(fp_n_out == e.fp_n, "R9 frame pulse", fp_n_out, e.fp_n);
        end
    end

    // Driver: one master clock of stimulus, applied at the falling edge.
    task automatic step(input bit fp_low, input bit c4_hold);
        @(negedge clk);
        ph++;
        c4_in   = c4_hold ? 1'b1 : ((ph % 4) < 2);
        fp_n_in = !fp_low;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    task automatic send_frame();
        while ((ph % 4) != 3) step(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        int t0;
        int e0;
        // R1: reset values
        repeat (3) @(posedge clk);
        #3;
        chk(tick_idx == 11'd0, "R1 reset index", int'(tick_idx), 0);
        chk(c4_out == 1'b0 && c2_out == 1'b1, "R1 reset clocks", {c4_out, c2_out}, 1);
        chk(fp_n_out == 1'b0 && cm_fp_n == 1'b1, "R1 reset pulses", {fp_n_out, cm_fp_n}, 1);
        chk(dm_fp == 1'b0 && dm_fp_n == 1'b1, "R1 reset data-memory pair", {dm_fp, dm_fp_n}, 1);
        @(negedge clk);
        rst = 1'b0;

        // R2: free run across the wrap
        run(2100);

        // R3: realign mid-frame with no delay, then two frames
        send_frame();
        run(4200);

        // R10: frame pulse low without a 4 MHz falling edge
        @(posedge clk);
        #3;
        t0 = int'(tick_idx);
        e0 = edges;
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1);
        run(8);
        @(posedge clk);
        #3;
        chk(int'(tick_idx) == (t0 + edges - e0) % 2048, "R10 ignored pulse",
            int'(tick_idx), (t0 + edges - e0) % 2048);

        // R4: delayed realignment, then two frames
        @(negedge clk);
        dly_sel = 1'b1;
        run(37);
        send_frame();
        run(4200);

        finish_run();
    end

endmodule